// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory with Miss Classification

This block holds the tag, valid, dirty and replacement state of a set-associative cache, without the data storage. Each lookup request carries an address and an access kind. The address is cut into a tag, a set index and a byte offset. The block compares the tag against every way of the indexed set and updates the directory in the same clock edge. One cycle later it reports which way was used and how the access was resolved.

There are four outcomes. A hit is a valid matching way. A plain miss fills a way that was still empty. When the set is full, a victim chosen by a tree pseudo-LRU is replaced, and the outcome says whether that victim was clean or dirty. Because of this classification, a trace of requests and outcomes is enough to check the replacement and write-back behaviour of a real cache.

Two commands need no tag lookup. A flush walks all sets, one set per cycle, and clears the dirty bits while keeping the lines resident. An invalidate empties the whole directory in a single edge.

Top module: `cache_dir`

## Requirements
- R1: The address is split with the tag in the top TAG_W bits and the set index in the next SET_W bits. The remaining low bits are the offset, which has no effect on the lookup. With the defaults, 0xA3E6 gives tag 0xA3, set 0xE and offset 0x6.
- R2: A lookup reports outcome 2'b00 (hit) when a valid way of the indexed set holds the request tag. The way output then gives that way.
- R3: A lookup that hits nothing while the set still has an invalid way reports 2'b01 (miss) and fills the lowest-numbered invalid way. Successive misses to an empty set therefore fill ways 0, 1, 2, 3 in that order.
- R4: A lookup that hits nothing in a full set replaces the pseudo-LRU victim. It reports 2'b11 when the victim was dirty and 2'b10 when it was clean.
- R5: A write (kind 1) or an atomic access (kind 2) marks the line dirty, whether it hits or fills. A read (kind 0) fill leaves the new line clean, and a read hit does not change the dirty state.
- R6: Every lookup updates the set's replacement tree with the way it hit or filled. Each tree node on that way's path is set to point away from it, and the victim is found by following the node pointers from the root (node 1 selects the upper half).
- R7: An invalidate command (kind 4) clears all valid bits, all dirty bits and all replacement state in one edge, and gives no lookup response.
- R8: A flush command (kind 3) does no tag lookup and gives no response. It keeps every line valid, clears the dirty bits of one set per cycle, and holds flush_busy high for NUM_SETS cycles. It then pulses flush_done for exactly one cycle.
- R9: While flush_busy is high, every request is ignored, including invalidate and flush commands.
- R10: The response (resp_valid, resp_code, resp_way) appears in the cycle after the accepted lookup strobe. resp_valid stays high for one cycle per lookup only.
- R11: After reset all lines are invalid and clean, the replacement state is zero, and resp_valid, flush_busy and flush_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | 0 read, 1 write, 2 atomic, 3 flush, 4 invalidate |
| req_addr | input | ADDR_W | Request address |
| resp_valid | output | 1 | Lookup result valid |
| resp_code | output | 2 | 00 hit, 01 miss, 10 clean evict, 11 dirty evict |
| resp_way | output | WAY_W | Way that was hit or written |
| flush_busy | output | 1 | Flush walk in progress |
| flush_done | output | 1 | One-cycle pulse at the end of a flush walk |

## Verification
A corrupted tag or valid bit shows up as a wrong hit or miss on the next access to that set, one cycle after the strobe. A wrong dirty bit stays hidden until its line is chosen as a victim, where the outcome shows 2'b10 and 2'b11 swapped. Faults in the replacement tree are only visible once a set is full, as a wrong victim way. For this reason the stimulus fills sets completely, steers the tree through each of its paths with hits, and then forces evictions before and after a flush. Flush and invalidate faults are exposed by replaying lines that should have stayed resident or should have been emptied.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

    typedef enum logic [2:0] {
        KIND_READ   = 3'd0,
        KIND_WRITE  = 3'd1,
        KIND_ATOMIC = 3'd2,
        KIND_FLUSH  = 3'd3,
        KIND_INVAL  = 3'd4
    } req_kind_e;

    typedef enum logic [1:0] {
        RES_HIT      = 2'b00,
        RES_MISS     = 2'b01,
        RES_CLEAN_EV = 2'b10,
        RES_DIRTY_EV = 2'b11
    } res_code_e;

    function automatic logic kind_is_lookup(input logic [2:0] k);
        return (k == KIND_READ) || (k == KIND_WRITE) || (k == KIND_ATOMIC);
    endfunction

    function automatic logic kind_sets_dirty(input logic [2:0] k);
        return (k == KIND_WRITE) || (k == KIND_ATOMIC);
    endfunction

endpackage

// File: rtl/cache_dir_addr_split.sv
module cache_dir_addr_split #(
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 8,
    parameter int SET_W  = 4,
    localparam int OFF_W = ADDR_W - TAG_W - SET_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [SET_W-1:0]  set_idx,
    output logic [OFF_W-1:0]  offset
);
    assign tag     = addr[ADDR_W-1 -: TAG_W];
    assign set_idx = addr[OFF_W +: SET_W];
    assign offset  = addr[OFF_W-1:0];
endmodule

// File: rtl/cache_dir_plru.sv
module cache_dir_plru #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int LRU_W = WAYS - 1,
    localparam int IX_W  = (LRU_W > 1) ? $clog2(LRU_W) : 1
) (
    input  logic [LRU_W-1:0] state,
    input  logic [WAY_W-1:0] touch_way,
    output logic [LRU_W-1:0] next_state,
    output logic [WAY_W-1:0] victim
);
    logic [IX_W-1:0] ix_u;
    logic [IX_W-1:0] ix_v;

    // heap-ordered tree: node n has children 2n+1 (lower half) and 2n+2
    always_comb begin
        next_state = state;
        ix_u = '0;
        for (int l = 0; l < WAY_W; l++) begin
            ix_u = IX_W'((2 ** l) - 1 + int'(touch_way >> (WAY_W - l)));
            next_state[ix_u] = ~touch_way[WAY_W-1-l];
        end
    end

    always_comb begin
        victim = '0;
        ix_v = '0;
        for (int l = 0; l < WAY_W; l++) begin
            ix_v = IX_W'((2 ** l) - 1 + int'(victim >> (WAY_W - l)));
            victim[WAY_W-1-l] = state[ix_v];
        end
    end
endmodule

// File: rtl/cache_dir_flush_walk.sv
module cache_dir_flush_walk #(
    parameter int NUM_SETS = 16,
    localparam int SET_W = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic [SET_W-1:0] set_idx,
    output logic             done
);
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            set_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    set_idx <= '0;
                end
            end else begin
                set_idx <= set_idx + 1'b1;
                if (set_idx == LAST_SET) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R8: the done pulse lasts one cycle and marks the end of a walk
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_after_walk_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    // R8: a walk visits the last set just before it ends
    assert_walk_ends_last_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(set_idx) == LAST_SET);
endmodule

// File: rtl/cache_dir.sv
module cache_dir
    import cache_dir_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int TAG_W    = 8,
    parameter int NUM_SETS = 16,
    parameter int WAYS     = 4,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int OFF_W   = ADDR_W - TAG_W - SET_W,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int LRU_W   = WAYS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic [WAY_W-1:0]  resp_way,
    output logic              flush_busy,
    output logic              flush_done
);
    // directory state
    logic [TAG_W-1:0] tag_q   [NUM_SETS][WAYS];
    logic [WAYS-1:0]  valid_q [NUM_SETS];
    logic [WAYS-1:0]  dirty_q [NUM_SETS];
    logic [LRU_W-1:0] lru_q   [NUM_SETS];

    // address fields
    logic [TAG_W-1:0] req_tag;
    logic [SET_W-1:0] req_set;
    logic [OFF_W-1:0] req_off;

    cache_dir_addr_split #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .SET_W(SET_W)) u_split (
        .addr    (req_addr),
        .tag     (req_tag),
        .set_idx (req_set),
        .offset  (req_off)
    );

    // request decode
    logic accept, lookup_fire, flush_fire, inval_fire;
    logic [SET_W-1:0] walk_idx;

    assign accept      = req_valid && !flush_busy;
    assign lookup_fire = accept && kind_is_lookup(req_kind);
    assign flush_fire  = accept && (req_kind == KIND_FLUSH);
    assign inval_fire  = accept && (req_kind == KIND_INVAL);

    cache_dir_flush_walk #(.NUM_SETS(NUM_SETS)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .start   (flush_fire),
        .busy    (flush_busy),
        .set_idx (walk_idx),
        .done    (flush_done)
    );

    // tag compare across ways
    logic [WAYS-1:0]  row_valid, row_dirty, hit_vec;
    logic [LRU_W-1:0] row_lru, lru_next;

    assign row_valid = valid_q[req_set];
    assign row_dirty = dirty_q[req_set];
    assign row_lru   = lru_q[req_set];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = row_valid[w] && (tag_q[req_set][w] == req_tag);
    end

    logic             any_hit, any_free;
    logic [WAY_W-1:0] hit_way, free_way, victim_way, chosen_way;
    res_code_e        outcome;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!row_valid[w]) free_way = WAY_W'(w);
        end
    end

    assign any_hit  = |hit_vec;
    assign any_free = ~&row_valid;

    cache_dir_plru #(.WAYS(WAYS)) u_plru (
        .state      (row_lru),
        .touch_way  (chosen_way),
        .next_state (lru_next),
        .victim     (victim_way)
    );

    always_comb begin
        if (any_hit) begin
            chosen_way = hit_way;
            outcome    = RES_HIT;
        end else if (any_free) begin
            chosen_way = free_way;
            outcome    = RES_MISS;
        end else begin
            chosen_way = victim_way;
            outcome    = row_dirty[victim_way] ? RES_DIRTY_EV : RES_CLEAN_EV;
        end
    end

    // directory update
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                lru_q[s]   <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                end
            end
        end else begin
            if (inval_fire) begin
                for (int s = 0; s < NUM_SETS; s++) begin
                    valid_q[s] <= '0;
                    dirty_q[s] <= '0;
                    lru_q[s]   <= '0;
                end
            end
            if (flush_busy) begin
                dirty_q[walk_idx] <= '0;
            end
            if (lookup_fire) begin
                tag_q[req_set][chosen_way]   <= req_tag;
                valid_q[req_set][chosen_way] <= 1'b1;
                lru_q[req_set]               <= lru_next;
                if (!any_hit) begin
                    dirty_q[req_set][chosen_way] <= kind_sets_dirty(req_kind);
                end else if (kind_sets_dirty(req_kind)) begin
                    dirty_q[req_set][chosen_way] <= 1'b1;
                end
            end
        end
    end

    // response register
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_code  <= RES_HIT;
            resp_way   <= '0;
        end else begin
            resp_valid <= lookup_fire;
            if (lookup_fire) begin
                resp_code <= outcome;
                resp_way  <= chosen_way;
            end
        end
    end

    // R1: the three fields cover the address exactly
    assert_split_covers_R1: assert property (@(posedge clk) disable iff (rst)
        lookup_fire |-> ({req_tag, req_set, req_off} == req_addr));
    // R2: a tag is never resident twice in one set
    assert_hit_unique_R2: assert property (@(posedge clk) disable iff (rst)
        lookup_fire |-> $onehot0(hit_vec));
    // R3: a fill with free ways reports a miss next cycle
    assert_free_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (lookup_fire && !any_hit && any_free) |=> (resp_code == RES_MISS));
    // R4: a full set with no hit reports an eviction
    assert_full_evicts_R4: assert property (@(posedge clk) disable iff (rst)
        (lookup_fire && !any_hit && !any_free) |=> resp_code[1]);
    // R7: invalidate empties the directory
    assert_inval_empties_R7: assert property (@(posedge clk) disable iff (rst)
        inval_fire |=> (valid_q[0] == '0) && (valid_q[NUM_SETS-1] == '0));
    // R9: requests during a walk produce no response
    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (rst)
        (flush_busy && req_valid) |=> !resp_valid);
    // R10: response follows an accepted lookup by one cycle
    assert_resp_follows_R10: assert property (@(posedge clk) disable iff (rst)
        lookup_fire |=> resp_valid);
    assert_resp_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(lookup_fire));
endmodule

// File: tb/cache_dir_tb_top.sv
module cache_dir_tb_top;
    localparam logic [2:0] K_RD = 3'd0, K_WR = 3'd1, K_AT = 3'd2, K_FL = 3'd3, K_IN = 3'd4;
    localparam int NVEC = 26;

    // {kind, addr, expected code, expected way}
    localparam logic [22:0] VEC [NVEC] = '{
        {K_RD, 16'hABCD, 2'b01, 2'd0},  // R3 empty set fills way 0
        {K_RD, 16'hABCD, 2'b00, 2'd0},  // R2
        {K_WR, 16'hABCD, 2'b00, 2'd0},  // R5 write hit makes way 0 dirty
        {K_RD, 16'hACCD, 2'b01, 2'd1},
        {K_RD, 16'hADCD, 2'b01, 2'd2},
        {K_RD, 16'hAECD, 2'b01, 2'd3},
        {K_RD, 16'hABCD, 2'b00, 2'd0},  // R6 steer tree
        {K_RD, 16'hADCD, 2'b00, 2'd2},
        {K_RD, 16'hAFCD, 2'b10, 2'd1},  // R6 victim way 1
        {K_RD, 16'hACCD, 2'b10, 2'd3},
        {K_RD, 16'hEAC2, 2'b11, 2'd0},  // R5 dirty victim
        {K_RD, 16'hEAC2, 2'b00, 2'd0},
        {K_RD, 16'h1234, 2'b01, 2'd0},
        {K_AT, 16'h2638, 2'b01, 2'd1},  // R5 atomic fill dirty
        {K_RD, 16'hA3E6, 2'b01, 2'd0},  // R1 set E
        {K_RD, 16'hA3E0, 2'b00, 2'd0},  // R1 offset ignored
        {K_RD, 16'h4630, 2'b01, 2'd2},
        {K_RD, 16'h5630, 2'b01, 2'd3},
        {K_RD, 16'h6630, 2'b10, 2'd0},
        {K_RD, 16'h4630, 2'b00, 2'd2},
        {K_RD, 16'h7630, 2'b11, 2'd1},  // R5 atomic line evicted dirty
        {K_RD, 16'h11C0, 2'b10, 2'd2},
        {K_WR, 16'h22C0, 2'b10, 2'd1},  // R5 write fill dirty
        {K_RD, 16'h33C0, 2'b10, 2'd3},
        {K_RD, 16'h44C0, 2'b10, 2'd0},
        {K_RD, 16'h22C5, 2'b00, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = '0;
    logic        resp_valid;
    logic [1:0]  resp_code;
    logic [1:0]  resp_way;
    logic        flush_busy, flush_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cache_dir dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_code(resp_code),
        .resp_way(resp_way), .flush_busy(flush_busy), .flush_done(flush_done)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // drive one request; return sampled 1 ns after the capturing edge
    task automatic issue(input logic [2:0] k, input logic [15:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_addr  = a;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic expect_lookup(input logic [2:0] k, input logic [15:0] a,
                                 input logic [1:0] code, input logic [1:0] way,
                                 input string what);
        issue(k, a);
        check(resp_valid && resp_code == code && resp_way == way, what,
              {resp_valid, resp_code, resp_way}, {1'b1, code, way});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        string lbl;
        int cyc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        check(!resp_valid && !flush_busy && !flush_done, "R11 reset outputs",
              {resp_valid, flush_busy, flush_done}, 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][3:2])
                2'b00:   lbl = "R2 hit";
                2'b01:   lbl = "R3 fill lowest free way";
                2'b10:   lbl = "R4 R6 clean victim";
                default: lbl = "R4 R5 dirty victim";
            endcase
            expect_lookup(VEC[i][22:20], VEC[i][19:4], VEC[i][3:2], VEC[i][1:0],
                          $sformatf("%s vec %0d", lbl, i));
        end

        // R10 response lasts one cycle
        @(posedge clk); #1;
        check(!resp_valid, "R10 single-cycle response", resp_valid, 0);

        // R1 offset bits do not affect the lookup
        expect_lookup(K_RD, 16'hA3EF, 2'b00, 2'd0, "R1 offset ignored");

        // R8 flush walk length and done pulse
        issue(K_FL, 16'h0000);
        check(!resp_valid, "R8 flush gives no response", resp_valid, 0);
        cyc = 0;
        while (flush_busy && cyc < 100) begin
            cyc++;
            @(posedge clk); #1;
        end
        check(cyc == 16, "R8 flush busy cycles", cyc, 16);
        check(flush_done, "R8 done pulse", flush_done, 1);
        @(posedge clk); #1;
        check(!flush_done, "R8 done single cycle", flush_done, 0);

        // R9 requests during a walk are ignored
        issue(K_FL, 16'h0000);
        issue(K_RD, 16'h99C0);
        check(!resp_valid, "R9 lookup ignored while busy", resp_valid, 0);
        issue(K_IN, 16'h0000);
        while (flush_busy) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;

        // R8 lines stay valid, dirty bits cleared; R9 invalidate had no effect
        expect_lookup(K_RD, 16'h22C0, 2'b00, 2'd1, "R8 R9 line kept after flush");
        expect_lookup(K_RD, 16'h44C0, 2'b00, 2'd0, "R9 invalidate ignored");
        expect_lookup(K_RD, 16'h11C0, 2'b00, 2'd2, "R6 steer to way 1");
        expect_lookup(K_RD, 16'h55C0, 2'b10, 2'd1, "R8 flushed line evicts clean");

        // R7 invalidate empties the directory
        issue(K_IN, 16'h0000);
        check(!resp_valid, "R7 invalidate gives no response", resp_valid, 0);
        expect_lookup(K_RD, 16'h55C0, 2'b01, 2'd0, "R7 set C empty");
        expect_lookup(K_WR, 16'h66C0, 2'b01, 2'd1, "R7 next free way");
        expect_lookup(K_RD, 16'h6630, 2'b01, 2'd0, "R7 set 3 empty");
        expect_lookup(K_RD, 16'hA3E6, 2'b01, 2'd0, "R7 set E empty");

        finish_run();
    end
endmodule